// File: doc/BRIEF.md
# Memory Fence Retirement Tracker

This block sits beside the load/store path of one core and decides when a memory fence may retire. It keeps two up/down counters, one for reads and one for writes, that count accesses sent to the memory system and not yet acknowledged. A counter at zero means that every access of that kind issued so far has completed.

A fence arrives with a kind code and, for the configurable kind, a four-bit ordering mask. The mask says which older access kinds must drain before the fence retires, and which younger access kinds the pipeline must hold back while the fence waits. One fence is tracked at a time. A second request is back-pressured until the first one retires.

Top module: `fence_tracker`

## Requirements
- R1: A read (write) issue pulse without an acknowledge raises `rd_cnt` (`wr_cnt`) by one on the next clock edge. The count saturates at 2^CNT_W-1.
- R2: An acknowledge pulse without an issue lowers the matching counter by one on the next clock edge.
- R3: An issue and an acknowledge of the same kind in one cycle leave that counter unchanged.
- R4: An acknowledge that arrives while its counter is zero leaves the counter at zero. It also sets `cnt_err`, which stays high until reset.
- R5: `fence_ready` is high exactly when no fence is pending. A request is accepted only when `fence_req` and `fence_ready` are both high. A request made while a fence is pending has no effect on the pending fence.
- R6: The kind is decoded into an ordering mask with bit0 = read-before-read, bit1 = read-before-write, bit2 = write-before-read and bit3 = write-before-write. Kind 2'b00 is a full barrier (mask 4'b1111). Kind 2'b01 is a write-only barrier (4'b1000). Kinds 2'b10 and 2'b11 take `fence_mask` as given.
- R7: While a fence is pending, `fence_done` is high in each cycle in which every counter the fence waits on is zero. The fence waits on the read counter if mask bit0 or bit1 is set, and on the write counter if bit2 or bit3 is set. The fence retires at the end of that cycle, so `fence_ready` is high in the next cycle. An empty mask retires in the first cycle after acceptance.
- R8: While a fence is pending and not done, `hold_rd` is high if mask bit0 or bit2 is set, and `hold_wr` is high if bit1 or bit3 is set. Both are low otherwise.
- R9: After reset both counters are zero, no fence is pending, `fence_ready` is high, and `fence_done`, `hold_rd`, `hold_wr` and `cnt_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_issue | input | 1 | A read was sent to memory this cycle |
| rd_ack | input | 1 | A read completed this cycle |
| wr_issue | input | 1 | A write was sent to memory this cycle |
| wr_ack | input | 1 | A write completed this cycle |
| fence_req | input | 1 | Fence request |
| fence_kind | input | 2 | Fence kind: full, write-only, masked |
| fence_mask | input | 4 | Ordering mask used by the masked kinds |
| fence_ready | output | 1 | No fence pending; a request is accepted |
| fence_done | output | 1 | Pending fence retires this cycle |
| hold_rd | output | 1 | Younger reads must wait |
| hold_wr | output | 1 | Younger writes must wait |
| cnt_err | output | 1 | Sticky acknowledge-underflow flag |
| rd_cnt | output | CNT_W | Outstanding read count |
| wr_cnt | output | CNT_W | Outstanding write count |

## Verification
The hardest situation to reach is a fence that waits on one counter while the other counter is still busy. Only then does a wrong decode of the mask show up as an early or late `fence_done`. Directed sequences build up both reads and writes first and then issue a write-only fence and a read-to-read masked fence, so that exactly one counter gates each of them. Saturation at the top count also needs a long run of unacknowledged issues, which is driven directly. Random traffic then mixes the fence kinds with random masks and biased issue and acknowledge rates.

// File: rtl/fence_pkg.sv
package fence_pkg;

    // Bit positions inside an ordering mask (older kind before younger kind)
    localparam int ORD_RR = 0;
    localparam int ORD_RW = 1;
    localparam int ORD_WR = 2;
    localparam int ORD_WW = 3;
    localparam int ORD_W  = 4;

    typedef enum logic [1:0] {
        FK_FULL    = 2'b00,
        FK_WRONLY  = 2'b01,
        FK_MASKED  = 2'b10,
        FK_MASKED2 = 2'b11
    } fence_kind_e;

    typedef struct packed {
        logic             pending;
        logic [ORD_W-1:0] mask;
        logic             err;
    } fence_state_t;

endpackage

// File: rtl/access_counter.sv
module access_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             underflow
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        underflow = 1'b0;
        if (inc && !dec) begin
            if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
        end else if (dec && !inc) begin
            if (cnt_q == '0) underflow = 1'b1;
            else             cnt_d     = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/fence_mask_decode.sv
module fence_mask_decode
    import fence_pkg::*;
(
    input  logic [1:0]       kind,
    input  logic [ORD_W-1:0] custom,
    output logic [ORD_W-1:0] eff
);
    always_comb begin
        case (kind)
            FK_FULL:   eff = '1;
            FK_WRONLY: eff = ORD_W'(1) << ORD_WW;
            default:   eff = custom;
        endcase
    end

endmodule

// File: rtl/fence_tracker.sv
module fence_tracker
    import fence_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_issue,
    input  logic             rd_ack,
    input  logic             wr_issue,
    input  logic             wr_ack,
    input  logic             fence_req,
    input  logic [1:0]       fence_kind,
    input  logic [3:0]       fence_mask,
    output logic             fence_ready,
    output logic             fence_done,
    output logic             hold_rd,
    output logic             hold_wr,
    output logic             cnt_err,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [CNT_W-1:0] wr_cnt
);
    localparam int NKIND = 2;   // index 0 = reads, 1 = writes

    logic [NKIND-1:0] inc_v, dec_v, uf_v;
    logic [CNT_W-1:0] cnt_v [NKIND];
    logic [ORD_W-1:0] req_mask;

    assign inc_v = {wr_issue, rd_issue};
    assign dec_v = {wr_ack, rd_ack};

    for (genvar k = 0; k < NKIND; k++) begin : g_cnt
        access_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc       (inc_v[k]),
            .dec       (dec_v[k]),
            .count     (cnt_v[k]),
            .underflow (uf_v[k])
        );
    end

    fence_mask_decode u_dec (
        .kind   (fence_kind),
        .custom (fence_mask),
        .eff    (req_mask)
    );

    fence_state_t st_d, st_q;
    logic wait_rd, wait_wr, clear_c;

    always_comb begin
        st_d    = st_q;
        wait_rd = st_q.mask[ORD_RR] | st_q.mask[ORD_RW];
        wait_wr = st_q.mask[ORD_WR] | st_q.mask[ORD_WW];
        clear_c = st_q.pending
                & (!wait_rd || cnt_v[0] == '0)
                & (!wait_wr || cnt_v[1] == '0);
        if (clear_c) begin
            st_d.pending = 1'b0;
        end else if (!st_q.pending && fence_req) begin
            st_d.pending = 1'b1;
            st_d.mask    = req_mask;
        end
        if (|uf_v) st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fence_ready = !st_q.pending;
    assign fence_done  = clear_c;
    assign hold_rd     = st_q.pending & !clear_c & (st_q.mask[ORD_RR] | st_q.mask[ORD_WR]);
    assign hold_wr     = st_q.pending & !clear_c & (st_q.mask[ORD_RW] | st_q.mask[ORD_WW]);
    assign cnt_err     = st_q.err;
    assign rd_cnt      = cnt_v[0];
    assign wr_cnt      = cnt_v[1];

endmodule

// File: rtl/fence_tracker_chk.sv
module fence_tracker_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_issue,
    input logic             rd_ack,
    input logic             wr_issue,
    input logic             wr_ack,
    input logic             fence_req,
    input logic [1:0]       fence_kind,
    input logic [3:0]       fence_mask,
    input logic             fence_ready,
    input logic             fence_done,
    input logic             hold_rd,
    input logic             hold_wr,
    input logic             cnt_err,
    input logic [CNT_W-1:0] rd_cnt,
    input logic [CNT_W-1:0] wr_cnt
);
    localparam logic [CNT_W-1:0] TOPV = '1;

    AST_WR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_issue && !wr_ack && wr_cnt != TOPV) |=> wr_cnt == $past(wr_cnt) + 1'b1); // R1
    AST_RD_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !rd_issue && rd_cnt != '0) |=> rd_cnt == $past(rd_cnt) - 1'b1); // R2
    AST_BOTH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_issue && wr_ack) |=> $stable(wr_cnt)); // R3
    AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !rd_issue && rd_cnt == '0) |=> (cnt_err && rd_cnt == '0)); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_err |=> cnt_err); // R4
    AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fence_ready && !fence_done) |=> !fence_ready); // R5
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req && fence_ready && fence_kind[1] && fence_mask == 4'b0000) |=> fence_done); // R6
    AST_DRAINED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fence_ready && rd_cnt == '0 && wr_cnt == '0) |-> fence_done); // R7
    AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |=> fence_ready); // R7
    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_rd || hold_wr) |-> (!fence_ready && !fence_done)); // R8

endmodule

bind fence_tracker fence_tracker_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/fence_tracker_bench.sv
module fence_tracker_bench;
    localparam int CLK_P = 10;
    localparam int CW    = 4;
    localparam int TOP   = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_issue = 0, rd_ack = 0, wr_issue = 0, wr_ack = 0, fence_req = 0;
    logic [1:0] fence_kind = 0;
    logic [3:0] fence_mask = 0;
    logic fence_ready, fence_done, hold_rd, hold_wr, cnt_err;
    logic [CW-1:0] rd_cnt, wr_cnt;

    int checks = 0;
    int fails  = 0;

    // bench model
    int  m_rc = 0, m_wc = 0;
    bit  m_pend = 0, m_err = 0;
    bit [3:0] m_mask = 0;

    always #(CLK_P/2) clk = ~clk;

    fence_tracker #(.CNT_W(CW)) u_fence_tracker (.*);

    function automatic bit [3:0] exp_mask(bit [1:0] k, bit [3:0] m);
        if (k == 2'b00) return 4'b1111;
        if (k == 2'b01) return 4'b1000;
        return m;
    endfunction

    function automatic bit exp_done();
        return m_pend && (!(m_mask[0] || m_mask[1]) || m_rc == 0)
                      && (!(m_mask[2] || m_mask[3]) || m_wc == 0);
    endfunction

    function automatic int cnt_next(int c, bit inc, bit dec, ref bit err);
        if (inc && !dec) return (c == TOP) ? c : c + 1;
        if (dec && !inc) begin
            if (c == 0) begin err = 1; return 0; end
            return c - 1;
        end
        return c;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit d;
        d = exp_done();
        chk("R5 fence_ready", int'(fence_ready), int'(!m_pend));
        chk("R7 fence_done", int'(fence_done), int'(d));
        chk("R6/R8 hold_rd", int'(hold_rd), int'(m_pend && !d && (m_mask[0] || m_mask[2])));
        chk("R6/R8 hold_wr", int'(hold_wr), int'(m_pend && !d && (m_mask[1] || m_mask[3])));
        chk("R1/R2/R3 rd_cnt", int'(rd_cnt), m_rc);
        chk("R1/R2/R3 wr_cnt", int'(wr_cnt), m_wc);
        chk("R4 cnt_err", int'(cnt_err), int'(m_err));
    endtask

    // sample outputs, drive one cycle of inputs, advance the model
    task automatic step(bit ri, bit ra, bit wi, bit wa, bit fr, bit [1:0] fk, bit [3:0] fm);
        bit d;
        @(negedge clk);
        compare();
        rd_issue = ri; rd_ack = ra; wr_issue = wi; wr_ack = wa;
        fence_req = fr; fence_kind = fk; fence_mask = fm;
        d = exp_done();
        if (d) m_pend = 0;
        else if (!m_pend && fr) begin m_pend = 1; m_mask = exp_mask(fk, fm); end
        m_rc = cnt_next(m_rc, ri, ra, m_err);
        m_wc = cnt_next(m_wc, wi, wa, m_err);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 2'b00, 4'b0000);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        #(CLK_P * 2 + 1);
        rst_n = 1'b1;
        // R9: reset state
        @(negedge clk);
        chk("R9 ready", int'(fence_ready), 1);
        chk("R9 done", int'(fence_done), 0);
        chk("R9 holds", int'({hold_rd, hold_wr}), 0);
        chk("R9 err", int'(cnt_err), 0);
        chk("R9 counts", int'({rd_cnt, wr_cnt}), 0);

        // full barrier with both kinds outstanding (R6 kind 00, R7, R8)
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 2'b00, 4'b0000);
        idle(2);
        step(0, 0, 0, 1, 1, 2'b10, 4'b0000);   // R5: request while pending ignored
        for (int i = 0; i < 2; i++) step(0, 1, 0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0);
        idle(3);

        // write-only barrier with reads still outstanding (R6 kind 01)
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 2'b01, 4'b0000);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, 0);
        idle(2);
        // masked read-to-read barrier with writes outstanding
        for (int i = 0; i < 2; i++) step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 2'b10, 4'b0001);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 0, 0);
        idle(2);
        // R3: issue and acknowledge together
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 0, 0);
        for (int i = 0; i < 2; i++) step(0, 0, 0, 1, 0, 0, 0);
        // R6: empty mask retires at once
        step(0, 0, 0, 0, 1, 2'b11, 4'b0000);
        idle(2);

        // R1 saturation
        for (int i = 0; i < TOP + 3; i++) step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 2'b10, 4'b0100);
        for (int i = 0; i < TOP; i++) step(0, 0, 0, 1, 0, 0, 0);
        idle(2);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            bit ri, ra, wi, wa, fr;
            ri = ($urandom % 3) == 0;
            wi = ($urandom % 3) == 0;
            ra = (m_rc > 0) && (($urandom % 3) == 0);
            wa = (m_wc > 0) && (($urandom % 3) == 0);
            fr = ($urandom % 6) == 0;
            step(ri, ra, wi, wa, fr, 2'($urandom), 4'($urandom));
        end
        // drain, then R4 underflow
        while (m_rc > 0 || m_wc > 0) step(0, m_rc > 0, 0, m_wc > 0, 0, 0, 0);
        idle(3);
        step(0, 1, 0, 0, 0, 0, 0);
        idle(3);
        step(1, 0, 0, 0, 0, 0, 0);
        idle(2);
        @(negedge clk);
        compare();
        finish_run();
    end

endmodule